// File: doc/BRIEF.md
# Single-Pole DC Blocking Filter

This block strips the constant offset from a signed sample stream that may deliver a new sample on every clock. For each accepted sample it takes the difference between the new input and the previous input, adds the previous output scaled by a pole of 1 - 2^-K, and reduces the result to 16 bits. The pole scaling uses a shift and a subtract, so the block needs no multiplier. The whole recursion closes within one clock, so there is no pipeline register anywhere in the feedback path.

The sum is formed with K fractional bits. Truncation to the output grid always rounds toward negative infinity. The fractional part that truncation drops is kept and added into the next sum, so truncation cannot leave a standing offset at the output. A two-state output sequencer marks when a result is fresh. State `ST_HOLD` means the output is stale. Transition `T_ACCEPT` moves the sequencer to `ST_EMIT` on any clock with a valid input. Transition `T_IDLE` moves it back to `ST_HOLD` on any clock without a valid input.

Top module: `dc_blocker_core`

## Requirements
- R1: Input and output samples are 16-bit two's-complement. For an accepted input x[n], the internal sum in units of 2^-K is W = 2^K*(x[n]-x[n-1]) + 2^K*y[n-1] - y[n-1] + r[n-1]. Here y is the previous output and r is the previous residue.
- R2: `out_vld` is high exactly in the cycle after a cycle with `in_vld` high, and low otherwise. A new `out_smp` appears in that same cycle.
- R3: When `in_vld` is low, `out_smp` and all filter state are held, whatever value `in_smp` has. The next valid sample gives the same result as if the idle cycles had never occurred.
- R4: The pole is 1 - 2^-K, with K a fixed parameter (default 6). The scaled feedback is y minus y arithmetically shifted right by K, and it is computed exactly at the internal precision.
- R5: The output is floor(W / 2^K), which rounds toward negative infinity. The residue r = W - 2^K*y lies in [0, 2^K) and is added into the next sum.
- R6: When floor(W / 2^K) exceeds 32767, the output is 32767. When it is below -32768, the output is -32768. In both cases the stored residue is zero.
- R7: While the input is held constant, the output reaches exactly 0 and then stays at 0, for both positive and negative constants.
- R8: While the input is held constant, the magnitude of the output never grows from one accepted sample to the next.
- R9: A synchronous `rst` clears the previous input, the previous output and the residue to zero, and drives `out_vld` low. The first sample after reset uses a previous input of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock; the sample rate is equal to this clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input sample strobe |
| in_smp | input | 16 | Signed input sample |
| out_vld | output | 1 | Output sample strobe, one cycle after `in_vld` |
| out_smp | output | 16 | Signed filtered sample, held between strobes |

## Verification
The hardest condition to reach from the ports is a steady state where the output integer has already reached zero or a small value, and only the hidden residue is still moving. For example, with an output of 1 the residue must drain by 2^-K per sample before the output drops to 0. Only a long run at a constant input gets there. The bench therefore holds a positive and a negative constant for thousands of samples, checks at every step that the magnitude does not grow, and then checks that the output stays at exactly zero. Saturation is reached with full-scale input swings from reset, where the first difference reaches ±65535.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    // Output sequencer states
    typedef enum logic {
        ST_HOLD = 1'b0,   // output is stale
        ST_EMIT = 1'b1    // output carries a fresh result
    } dcb_state_e;

    // Internal accumulator width: the sample width, K fractional bits,
    // and three guard bits. The guard bits hold the 17-bit difference
    // plus the 16-bit feedback term.
    function automatic int acc_width(input int dw, input int k);
        return dw + k + 3;
    endfunction

endpackage

// File: rtl/dcb_first_diff.sv
module dcb_first_diff #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 take,
    input  logic signed [DW-1:0] smp,
    output logic signed [DW:0]   diff
);

    logic signed [DW-1:0] prev_q;

    // Input delay: holds x[n-1]. It only moves on an accepted sample.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else if (take) begin
            prev_q <= smp;
        end
    end

    // One bit wider than the sample, so the difference never wraps
    always_comb begin
        diff = {smp[DW-1], smp} - {prev_q[DW-1], prev_q};
    end

endmodule

// File: rtl/dcb_loop_sum.sv
module dcb_loop_sum #(
    parameter int DW = 16,
    parameter int K  = 6,
    parameter int AW = dcb_pkg::acc_width(DW, K)
) (
    input  logic signed [DW:0]   diff,
    input  logic signed [DW-1:0] y_prev,
    input  logic        [K-1:0]  res_prev,
    output logic signed [AW-1:0] sum
);

    logic signed [AW-1:0] d_ext;
    logic signed [AW-1:0] y_ext;
    logic signed [AW-1:0] r_ext;
    logic signed [AW-1:0] pole_term;

    always_comb begin
        d_ext = {{(AW-DW-1){diff[DW]}}, diff};
        y_ext = {{(AW-DW){y_prev[DW-1]}}, y_prev};
        r_ext = {{(AW-K){1'b0}}, res_prev};
        // Scaled feedback in units of 2^-K: y*2^K - y equals (1 - 2^-K)*y
        // exactly at this precision.
        pole_term = (y_ext <<< K) - y_ext;
        sum = (d_ext <<< K) + pole_term + r_ext;
    end

endmodule

// File: rtl/dcb_quant.sv
module dcb_quant #(
    parameter int DW = 16,
    parameter int K  = 6,
    parameter int AW = dcb_pkg::acc_width(DW, K)
) (
    input  logic signed [AW-1:0] sum,
    output logic signed [DW-1:0] y_next,
    output logic        [K-1:0]  res_next,
    output logic                 sat_hi,
    output logic                 sat_lo
);

    localparam int IW = AW - K;
    localparam logic signed [IW-1:0] HI_LIM = IW'((2 ** (DW - 1)) - 1);
    localparam logic signed [IW-1:0] LO_LIM = -HI_LIM - IW'(1);

    logic signed [IW-1:0] int_part;

    always_comb begin
        // Dropping the low K bits of a two's-complement value floors it
        int_part = sum[AW-1:K];
        sat_hi   = int_part > HI_LIM;
        sat_lo   = int_part < LO_LIM;
        unique case ({sat_hi, sat_lo})
            2'b10: begin
                y_next   = HI_LIM[DW-1:0];
                res_next = '0;
            end
            2'b01: begin
                y_next   = LO_LIM[DW-1:0];
                res_next = '0;
            end
            default: begin
                y_next   = int_part[DW-1:0];
                res_next = sum[K-1:0];
            end
        endcase
    end

    // R6: the two saturation directions never occur together
    always_comb begin
        p_sat_exclusive_r6: assert (!(sat_hi && sat_lo));
    end

endmodule

// File: rtl/dc_blocker_core.sv
module dc_blocker_core #(
    parameter int DW = 16,
    parameter int K  = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [DW-1:0] in_smp,
    output logic          out_vld,
    output logic [DW-1:0] out_smp
);

    import dcb_pkg::*;

    localparam int AW = acc_width(DW, K);

    dcb_state_e state_q;
    dcb_state_e state_d;

    logic signed [DW:0]   diff;
    logic signed [AW-1:0] sum;
    logic signed [DW-1:0] y_q;
    logic signed [DW-1:0] y_next;
    logic        [K-1:0]  res_q;
    logic        [K-1:0]  res_next;
    logic                 sat_hi;
    logic                 sat_lo;

    dcb_first_diff #(.DW(DW)) u_diff (
        .clk  (clk),
        .rst  (rst),
        .take (in_vld),
        .smp  ($signed(in_smp)),
        .diff (diff)
    );

    dcb_loop_sum #(.DW(DW), .K(K), .AW(AW)) u_sum (
        .diff     (diff),
        .y_prev   (y_q),
        .res_prev (res_q),
        .sum      (sum)
    );

    dcb_quant #(.DW(DW), .K(K), .AW(AW)) u_quant (
        .sum      (sum),
        .y_next   (y_next),
        .res_next (res_next),
        .sat_hi   (sat_hi),
        .sat_lo   (sat_lo)
    );

    // Next state: T_ACCEPT on a valid sample, T_IDLE otherwise
    always_comb begin
        unique case (state_q)
            ST_HOLD: state_d = in_vld ? ST_EMIT : ST_HOLD;
            ST_EMIT: state_d = in_vld ? ST_EMIT : ST_HOLD;
            default: state_d = ST_HOLD;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Loop registers: previous output and residue
    always_ff @(posedge clk) begin
        if (rst) begin
            y_q   <= '0;
            res_q <= '0;
        end else if (in_vld) begin
            y_q   <= y_next;
            res_q <= res_next;
        end
    end

    // Outputs
    always_comb begin
        out_vld = (state_q == ST_EMIT);
        out_smp = y_q;
    end

    // R2: a valid sample gives a strobe on the next cycle
    p_vld_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    // R2: no valid sample, no strobe on the next cycle
    p_vld_drop_r2: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);

    // R3: the output is held through idle cycles
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(out_smp));

    // R7: at a zero output with a flat input, the output stays at zero
    p_zero_stays_r7: assert property (@(posedge clk) disable iff (rst)
        (in_vld && diff == '0 && y_q == '0) |=> (out_smp == '0));

    // R8: a positive output never grows under a flat input
    p_decay_pos_r8: assert property (@(posedge clk) disable iff (rst)
        (in_vld && diff == '0 && !y_q[DW-1])
        |=> ($signed(out_smp) <= $signed($past(y_q))));

    // R8: a negative output never grows in magnitude under a flat input
    p_decay_neg_r8: assert property (@(posedge clk) disable iff (rst)
        (in_vld && diff == '0 && y_q[DW-1])
        |=> ($signed(out_smp) >= $signed($past(y_q))));

    // R9: reset clears the strobe and the output
    p_reset_r9: assert property (@(posedge clk)
        rst |=> (!out_vld && out_smp == '0));

endmodule

// File: tb/dc_blocker_core_tb_top.sv
module dc_blocker_core_tb_top;

    localparam int DW = 16;
    localparam int K  = 6;
    localparam int TV_N = 5;

    // Hand-worked sequence from reset, K = 6
    localparam logic signed [15:0] TV_X [TV_N] = '{16'sd100, 16'sd100, 16'sd100, -16'sd50, 16'sd0};
    localparam logic signed [15:0] TV_Y [TV_N] = '{16'sd100, 16'sd98,  16'sd96,  -16'sd55, -16'sd4};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_vld = 1'b0;
    logic [DW-1:0] in_smp = '0;
    logic          out_vld;
    logic [DW-1:0] out_smp;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // Bench model state
    longint m_x = 0;
    longint m_y = 0;
    longint m_r = 0;

    always #2 clk = ~clk;

    dc_blocker_core #(.DW(DW), .K(K)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .in_smp  (in_smp),
        .out_vld (out_vld),
        .out_smp (out_smp)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sout();
        return longint'($signed(out_smp));
    endfunction

    function automatic longint floor_div(input longint a, input longint b);
        longint q;
        q = a / b;
        if ((a % b != 0) && (a < 0)) q = q - 1;
        return q;
    endfunction

    // Expected output, computed from R1, R4, R5 and R6
    function automatic longint model_step(input longint x);
        longint w;
        longint y;
        longint r;
        w = (x - m_x) * (1 << K) + m_y * (1 << K) - m_y + m_r;
        y = floor_div(w, 1 << K);
        r = w - y * (1 << K);
        if (y > 32767) begin y = 32767; r = 0; end
        if (y < -32768) begin y = -32768; r = 0; end
        m_x = x; m_y = y; m_r = r;
        return y;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_vld = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        m_x = 0; m_y = 0; m_r = 0;
    endtask

    // Drive one valid sample; return after the clock edge with the output settled
    task automatic push(input longint x);
        @(negedge clk);
        in_vld = 1'b1;
        in_smp = DW'(x);
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    initial begin
        #400000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        longint e;
        longint prev;
        bit grew;
        bit lcg_bad;
        int lcg;

        // R9: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset out_vld", longint'(out_vld), 0);
        check("R9 reset out_smp", sout(), 0);
        do_reset();

        // R1 R4 R5: hand-worked table
        for (int i = 0; i < TV_N; i++) begin
            push(longint'(TV_X[i]));
            e = model_step(longint'(TV_X[i]));
            check("R1 R4 R5 table vs model", e, longint'(TV_Y[i]));
            check("R1 R5 table output", sout(), longint'(TV_Y[i]));
            check("R2 out_vld after sample", longint'(out_vld), 1);
        end

        // R2 R3: idle cycles with a changing input are ignored
        idle();
        in_smp = 16'h7123;
        @(posedge clk); #1;
        check("R2 out_vld drops", longint'(out_vld), 0);
        @(negedge clk); in_smp = 16'h8001;
        @(posedge clk); #1;
        check("R3 held output", sout(), -4);
        @(negedge clk); in_smp = 16'h0555;
        @(posedge clk); #1;
        check("R3 held output 2", sout(), -4);
        push(7);
        e = model_step(7);
        check("R3 resume as if no gap", sout(), e);

        // R6: positive saturation then negative saturation
        do_reset();
        push(32767);  e = model_step(32767);
        check("R6 full positive", sout(), 32767);
        push(-32768); e = model_step(-32768);
        check("R6 saturate low", sout(), -32768);
        push(-32768); e = model_step(-32768);
        check("R6 zero residue after low sat", sout(), -32256);
        do_reset();
        push(-32768); e = model_step(-32768);
        push(32767);  e = model_step(32767);
        check("R6 saturate high", sout(), 32767);
        check("R6 model agrees", e, 32767);

        // R7 R8: positive constant decays to exactly zero
        do_reset();
        push(1000); e = model_step(1000);
        prev = sout();
        grew = 1'b0;
        for (int i = 0; i < 2500; i++) begin
            push(1000);
            if (sout() > prev || sout() < 0) grew = 1'b1;
            prev = sout();
        end
        check("R8 positive step never grows", longint'(grew), 0);
        check("R7 positive constant settles", sout(), 0);
        grew = 1'b0;
        for (int i = 0; i < 200; i++) begin
            push(1000);
            if (sout() != 0) grew = 1'b1;
        end
        check("R7 stays at zero", longint'(grew), 0);

        // R7 R8: negative constant
        do_reset();
        push(-1000);
        prev = sout();
        check("R9 first sample uses zero history", prev, -1000);
        grew = 1'b0;
        for (int i = 0; i < 2500; i++) begin
            push(-1000);
            if (sout() < prev || sout() > 0) grew = 1'b1;
            prev = sout();
        end
        check("R8 negative step never grows", longint'(grew), 0);
        check("R7 negative constant settles", sout(), 0);

        // R1 R10: pseudo-random stream against the model
        do_reset();
        lcg = 12345;
        lcg_bad = 1'b0;
        for (int i = 0; i < 400; i++) begin
            lcg = lcg * 1103515245 + 12345;
            e = longint'($signed(lcg[23:8]));
            if (i % 7 == 3) idle();
            push(e);
            e = model_step(e);
            if (sout() != e) begin
                lcg_bad = 1'b1;
                $display("FAIL R1 stream sample %0d: actual=%0d expected=%0d", i, sout(), e);
            end
        end
        check("R1 random stream", longint'(lcg_bad), 0);

        // R9: reset in mid-stream
        push(20000);
        @(negedge clk);
        rst = 1'b1;
        in_vld = 1'b0;
        @(posedge clk); #1;
        check("R9 mid-stream reset out", sout(), 0);
        check("R9 mid-stream reset vld", longint'(out_vld), 0);
        @(negedge clk);
        rst = 1'b0;
        m_x = 0; m_y = 0; m_r = 0;
        push(300);
        check("R9 restart from zero history", sout(), 300);

        idle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule